// File: doc/BRIEF.md
# Packed-Coordinate Rectangle Fill Engine

This engine carries out one rectangle-clear command. It is started with a single-cycle pulse. It then reads five 32-bit words from a packet buffer through a synchronous read port: the command word, a line-width word, an attribute word and two packed corner words. If the command word identifies a fill, the engine does three things:

- It removes the line width from both corner words and unpacks the coordinates.
- It turns the attribute into a fill value.
- It writes that value into every pixel of the rectangle, one pixel per clock, through a framebuffer write port.

A running dirty bounding box is widened by each accepted command. A display refresh agent can use it to limit the region it re-reads.

The pixel format is chosen by a mode input, either 8-bit indexed or 24-bit grey. Framebuffer addresses are linear pixel indices: `row * XSIZE + column`, with `XSIZE` defaulting to 1280. The frame height `FB_HEIGHT` defaults to 1024.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset, `busy`, `done` and `fbWrEn` are 0. The dirty box is empty: both minimum outputs are all ones (4095) and both maximum outputs are 0.
- R2: After `start` is accepted, the engine reads packet word indices 0, 4, 5, 6 and 7 (byte offsets 0, 16, 20, 24, 28). These hold, in that order, the command, line width, attribute, first corner and second corner. `pktRdData` is taken one cycle after the matching `pktRdEn`.
- R3: The command is executed only when word 0 equals exactly 0x00000411. Any other value causes no pixel writes and leaves the dirty box unchanged, but `done` still pulses.
- R4: Each corner word is first reduced by the raw line width, modulo 2^32. The column is then bits 29:19 of the result and the row is bits 12:3.
- R5: Columns run from x up to, but not including, x2. When x2 - x exceeds XSIZE, x2 is replaced by XSIZE itself.
- R6: Rows run from y up to, but not including, y2 + ((lw + 1) >> 2), where lw is the raw line width. The row end is capped at FB_HEIGHT.
- R7: In 24-bit mode (`pixDepth24`=1), the fill value is taken from attribute bits 23:16. A value of 0 gives grey 0x00, a value of 7 gives grey 0xC0, and any other value gives 0xFF. The grey level is repeated in all three bytes of `fbWrData`.
- R8: In 8-bit mode, `fbWrData` carries attribute bits 7:0 in its low byte, and its upper 16 bits are 0.
- R9: Pixels are written in row-major order, one per cycle, with `fbWrEn` held high continuously. `fbWrAddr` = row*XSIZE + column.
- R10: A rectangle with an empty column span or an empty row span produces no writes, and the command still completes with `done`.
- R11: Every accepted command widens the horizontal box to include x and the capped x2. The vertical box is widened to include the first and last rows written, and only when at least one pixel is written. The box never shrinks.
- R12: `busy` is high from the cycle after `start` until `done` is raised. `done` is a one-cycle pulse with `busy` low. A `start` that arrives while the engine is working is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin one command (honoured only when idle) |
| pixDepth24 | input | 1 | 1 selects 24-bit grey pixels, 0 selects 8-bit pixels |
| pktRdEn | output | 1 | Packet buffer read strobe |
| pktRdAddr | output | 3 | Packet word index |
| pktRdData | input | 32 | Packet word, valid one cycle after the strobe |
| fbWrEn | output | 1 | Framebuffer pixel write strobe |
| fbWrAddr | output | 21 | Linear pixel address |
| fbWrData | output | 24 | Pixel value |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| dirtyXMin | output | 12 | Dirty box left column |
| dirtyXMax | output | 12 | Dirty box right bound (capped x2) |
| dirtyYMin | output | 12 | Dirty box top row |
| dirtyYMax | output | 12 | Dirty box last row written |

## Verification
The in-line properties rely on three things about the environment:
- The packet buffer returns data exactly one cycle after each read strobe.
- `pixDepth24` stays steady while a command runs.
- Packet contents do not change during the fetch.

The stimulus respects all three. A one-cycle-latency memory model serves the packet words, and the packet and mode are loaded only while the engine is idle. The only `start` raised during a run is the one deliberately used to show that it is ignored. Corner words are built so that the line-width subtraction changes the row field, so a missing subtraction shows up as wrong addresses.

// File: rtl/rfill_pkg.sv
package rfill_pkg;

  localparam logic [31:0] FILL_OPCODE = 32'h0000_0411;
  localparam int COORD_W = 12;
  localparam int NUM_SLOTS = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SETUP, ST_CHECK, ST_FILL, ST_DONE
  } ctl_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic [2:0] slot;
    logic       latchGeom;
    logic       growX;
    logic       growY;
    logic       loadCursor;
    logic       stepPix;
  } dp_ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic matched;
    logic colEmpty;
    logic rowEmpty;
    logic lastPix;
  } dp_stat_t;

  // slot number -> packet word index
  function automatic logic [2:0] slot_word(input logic [2:0] idx);
    case (idx)
      3'd0:    return 3'd0;
      3'd1:    return 3'd4;
      3'd2:    return 3'd5;
      3'd3:    return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  // three-level grey from one attribute byte
  function automatic logic [7:0] grey_level(input logic [7:0] sel);
    if (sel == 8'd0)      return 8'h00;
    else if (sel == 8'd7) return 8'hC0;
    else                  return 8'hFF;
  endfunction

endpackage

// File: rtl/rfill_ctl.sv
module rfill_ctl
  import rfill_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  dp_stat_t   stat,
  output dp_ctl_t    ctl,
  output logic       pktRdEn,
  output logic [2:0] pktRdAddr,
  output logic       busy,
  output logic       done
);

  localparam logic [2:0] LAST_FETCH = 3'(NUM_SLOTS);

  ctl_state_t state;
  logic [2:0] fetchIdx;
  logic       fillable;

  assign fillable = stat.matched && !stat.colEmpty && !stat.rowEmpty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      fetchIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_FETCH;
          fetchIdx <= '0;
        end
        ST_FETCH: begin
          fetchIdx <= fetchIdx + 3'd1;
          if (fetchIdx == LAST_FETCH) state <= ST_SETUP;
        end
        ST_SETUP: state <= ST_CHECK;
        ST_CHECK: state <= fillable ? ST_FILL : ST_DONE;
        ST_FILL:  if (stat.lastPix) state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pktRdEn        = (state == ST_FETCH) && (fetchIdx < LAST_FETCH);
    pktRdAddr      = slot_word(fetchIdx);
    ctl            = '0;
    ctl.capture    = (state == ST_FETCH) && (fetchIdx != 3'd0);
    ctl.slot       = fetchIdx - 3'd1;
    ctl.latchGeom  = (state == ST_SETUP);
    ctl.growX      = (state == ST_CHECK) && stat.matched;
    ctl.growY      = (state == ST_CHECK) && fillable;
    ctl.loadCursor = (state == ST_CHECK) && fillable;
    ctl.stepPix    = (state == ST_FILL);
    busy           = (state != ST_IDLE) && (state != ST_DONE);
    done           = (state == ST_DONE);
  end

  // R12: completion is a single-cycle pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done held longer than one cycle");

  // R12: done never coincides with busy
  assert_done_not_busy_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("done while busy");

  // R2: a capture always follows a read strobe from the previous cycle
  assert_capture_after_read_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |-> $past(pktRdEn)) else $error("capture without read");

endmodule

// File: rtl/rfill_dp.sv
module rfill_dp
  import rfill_pkg::*;
#(
  parameter int XSIZE     = 1280,
  parameter int FB_HEIGHT = 1024,
  parameter int ADDR_W    = 21
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               pixDepth24,
  input  logic [31:0]        pktRdData,
  input  dp_ctl_t            ctl,
  output dp_stat_t           stat,
  output logic               fbWrEn,
  output logic [ADDR_W-1:0]  fbWrAddr,
  output logic [23:0]        fbWrData,
  output logic [COORD_W-1:0] dirtyXMin,
  output logic [COORD_W-1:0] dirtyXMax,
  output logic [COORD_W-1:0] dirtyYMin,
  output logic [COORD_W-1:0] dirtyYMax
);

  localparam logic [COORD_W-1:0] X_CAP = COORD_W'(XSIZE);
  localparam logic [COORD_W-1:0] Y_CAP = COORD_W'(FB_HEIGHT);
  localparam logic [ADDR_W-1:0]  ROW_STRIDE = ADDR_W'(XSIZE);

  logic [31:0] pktWord [NUM_SLOTS];

  // packet capture, one register per slot
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) pktWord[s] <= '0;
      else if (ctl.capture && ctl.slot == 3'(s)) pktWord[s] <= pktRdData;
    end
  end

  // decode
  logic [31:0] cmdW, lwW, attrW, cornA, cornB;
  logic [10:0] xA, xB;
  logic [9:0]  yA, yB;
  logic [COORD_W-1:0] xHiNext, yEndNext;
  logic [32:0] lwQuarter;
  logic [33:0] yEndWide;
  logic [23:0] fillNext;
  logic [7:0]  grey;

  always_comb begin
    cmdW  = pktWord[0];
    lwW   = pktWord[1];
    attrW = pktWord[2];
    cornA = pktWord[3] - lwW;
    cornB = pktWord[4] - lwW;
    xA = cornA[29:19];
    yA = cornA[12:3];
    xB = cornB[29:19];
    yB = cornB[12:3];
    if ((xB > xA) && (COORD_W'(xB - xA) > X_CAP)) xHiNext = X_CAP;
    else                                           xHiNext = COORD_W'(xB);
    lwQuarter = ({1'b0, lwW} + 33'd1) >> 2;
    yEndWide  = 34'(yB) + 34'(lwQuarter);
    if (yEndWide > 34'(FB_HEIGHT)) yEndNext = Y_CAP;
    else                           yEndNext = yEndWide[COORD_W-1:0];
    grey = grey_level(attrW[23:16]);
    fillNext = pixDepth24 ? {grey, grey, grey} : {16'h0000, attrW[7:0]};
  end

  // latched geometry
  logic [COORD_W-1:0] xLo, xHi, yLo, yHi;
  logic [23:0]        fillVal;
  logic               matched;

  always_ff @(posedge clk) begin
    if (rst) begin
      xLo <= '0; xHi <= '0; yLo <= '0; yHi <= '0;
      fillVal <= '0; matched <= 1'b0;
    end else if (ctl.latchGeom) begin
      xLo     <= COORD_W'(xA);
      xHi     <= xHiNext;
      yLo     <= COORD_W'(yA);
      yHi     <= yEndNext;
      fillVal <= fillNext;
      matched <= (cmdW == FILL_OPCODE);
    end
  end

  // pixel cursor
  logic [COORD_W-1:0] col, row;
  logic [ADDR_W-1:0]  rowBase;
  logic               lastCol, lastRow;

  assign lastCol = (col == xHi - COORD_W'(1));
  assign lastRow = (row == yHi - COORD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      col <= '0; row <= '0; rowBase <= '0;
    end else if (ctl.loadCursor) begin
      col     <= xLo;
      row     <= yLo;
      rowBase <= ADDR_W'(yLo) * ROW_STRIDE;
    end else if (ctl.stepPix) begin
      if (lastCol) begin
        col     <= xLo;
        row     <= row + COORD_W'(1);
        rowBase <= rowBase + ROW_STRIDE;
      end else begin
        col <= col + COORD_W'(1);
      end
    end
  end

  // dirty box
  always_ff @(posedge clk) begin
    if (rst) begin
      dirtyXMin <= '1; dirtyXMax <= '0;
      dirtyYMin <= '1; dirtyYMax <= '0;
    end else begin
      if (ctl.growX) begin
        if (xLo < dirtyXMin) dirtyXMin <= xLo;
        if (xHi > dirtyXMax) dirtyXMax <= xHi;
      end
      if (ctl.growY) begin
        if (yLo < dirtyYMin) dirtyYMin <= yLo;
        if (yHi - COORD_W'(1) > dirtyYMax) dirtyYMax <= yHi - COORD_W'(1);
      end
    end
  end

  assign stat.matched  = matched;
  assign stat.colEmpty = (xHi <= xLo);
  assign stat.rowEmpty = (yHi <= yLo);
  assign stat.lastPix  = lastCol && lastRow;

  assign fbWrEn   = ctl.stepPix;
  assign fbWrAddr = rowBase + ADDR_W'(col);
  assign fbWrData = fillVal;

  // R5: every written column lies in the span
  assert_col_in_span_R5: assert property (@(posedge clk) disable iff (rst)
    fbWrEn |-> (col >= xLo) && (col < xHi)) else $error("column outside span");

  // R6: every written row lies below the capped end
  assert_row_in_span_R6: assert property (@(posedge clk) disable iff (rst)
    fbWrEn |-> (row >= yLo) && (row < yHi) && (row < Y_CAP)) else $error("row outside span");

  // R9: consecutive writes within a row advance the address by one
  assert_addr_step_R9: assert property (@(posedge clk) disable iff (rst)
    (fbWrEn && $past(fbWrEn) && (col != xLo)) |-> (fbWrAddr == $past(fbWrAddr) + ADDR_W'(1)))
    else $error("address did not step");

  // R11: the dirty box only grows
  assert_box_grows_R11: assert property (@(posedge clk) disable iff (rst)
    (dirtyXMin <= $past(dirtyXMin)) && (dirtyYMin <= $past(dirtyYMin)) &&
    (dirtyXMax >= $past(dirtyXMax)) && (dirtyYMax >= $past(dirtyYMax)))
    else $error("dirty box shrank");

endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rfill_pkg::*;
#(
  parameter int XSIZE     = 1280,
  parameter int FB_HEIGHT = 1024,
  localparam int ADDR_W   = $clog2((FB_HEIGHT - 1) * XSIZE + 2048)
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               pixDepth24,
  output logic               pktRdEn,
  output logic [2:0]         pktRdAddr,
  input  logic [31:0]        pktRdData,
  output logic               fbWrEn,
  output logic [ADDR_W-1:0]  fbWrAddr,
  output logic [23:0]        fbWrData,
  output logic               busy,
  output logic               done,
  output logic [COORD_W-1:0] dirtyXMin,
  output logic [COORD_W-1:0] dirtyXMax,
  output logic [COORD_W-1:0] dirtyYMin,
  output logic [COORD_W-1:0] dirtyYMax
);

  dp_ctl_t  ctl;
  dp_stat_t stat;

  rfill_ctl u_ctl (
    .clk(clk), .rst(rst), .start(start), .stat(stat), .ctl(ctl),
    .pktRdEn(pktRdEn), .pktRdAddr(pktRdAddr), .busy(busy), .done(done)
  );

  rfill_dp #(.XSIZE(XSIZE), .FB_HEIGHT(FB_HEIGHT), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .pixDepth24(pixDepth24), .pktRdData(pktRdData),
    .ctl(ctl), .stat(stat), .fbWrEn(fbWrEn), .fbWrAddr(fbWrAddr),
    .fbWrData(fbWrData), .dirtyXMin(dirtyXMin), .dirtyXMax(dirtyXMax),
    .dirtyYMin(dirtyYMin), .dirtyYMax(dirtyYMax)
  );

endmodule

// File: tb/rect_fill_engine_bench.sv
`timescale 1ns/1ps
module rect_fill_engine_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic pixDepth24 = 1'b0;
  logic pktRdEn;
  logic [2:0] pktRdAddr;
  logic [31:0] pktRdData;
  logic fbWrEn;
  logic [20:0] fbWrAddr;
  logic [23:0] fbWrData;
  logic busy, done;
  logic [11:0] dirtyXMin, dirtyXMax, dirtyYMin, dirtyYMax;

  always #2.5 clk = ~clk;

  rect_fill_engine u_rect_fill_engine (
    .clk(clk), .rst(rst), .start(start), .pixDepth24(pixDepth24),
    .pktRdEn(pktRdEn), .pktRdAddr(pktRdAddr), .pktRdData(pktRdData),
    .fbWrEn(fbWrEn), .fbWrAddr(fbWrAddr), .fbWrData(fbWrData),
    .busy(busy), .done(done), .dirtyXMin(dirtyXMin), .dirtyXMax(dirtyXMax),
    .dirtyYMin(dirtyYMin), .dirtyYMax(dirtyYMax)
  );

  // packet memory with one-cycle read latency
  logic [31:0] pkt [8];
  always @(posedge clk) if (pktRdEn) pktRdData <= pkt[pktRdAddr];

  int errors = 0;
  int checks = 0;
  int expAddr[$];
  int expData[$];
  string curTag = "R9";
  int eXMin = 4095, eXMax = 0, eYMin = 4095, eYMax = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each write with the scoreboard
  always @(negedge clk) begin
    if (!rst && fbWrEn) begin
      if (expAddr.size() == 0) begin
        check({curTag, " unexpected write addr"}, fbWrAddr, -1);
      end else begin
        check({curTag, " write addr"}, fbWrAddr, expAddr.pop_front());
        check({curTag, " write data"}, fbWrData, expData.pop_front());
      end
    end
  end

  function automatic logic [31:0] packXY(input int x, input int y);
    return (32'(x) << 19) | (32'(y) << 3);
  endfunction

  function automatic int greyOf(input logic [7:0] s);
    if (s == 0) return 0;
    if (s == 7) return 8'hC0;
    return 8'hFF;
  endfunction

  task automatic runCase(input string tag, input logic [31:0] cmd, input logic [31:0] lw,
                         input logic [31:0] attr, input logic [31:0] v1, input logic [31:0] v2,
                         input logic d24, input bit pokeStart);
    logic [31:0] a, b;
    int x, y, x2, y2, rowEnd, val, g;
    longint lwq;
    curTag = tag;
    a = v1 - lw; b = v2 - lw;
    x = int'(a[29:19]); y = int'(a[12:3]);
    x2 = int'(b[29:19]); y2 = int'(b[12:3]);
    if (x2 - x > 1280) x2 = 1280;
    lwq = (longint'(lw) + 1) >> 2;
    rowEnd = (longint'(y2) + lwq > 1024) ? 1024 : int'(longint'(y2) + lwq);
    g = greyOf(attr[23:16]);
    val = d24 ? ((g << 16) | (g << 8) | g) : int'(attr[7:0]);
    if (cmd == 32'h411) begin
      for (int r = y; r < rowEnd; r++)
        for (int c = x; c < x2; c++) begin
          expAddr.push_back(r * 1280 + c);
          expData.push_back(val);
        end
      if (x < eXMin) eXMin = x;
      if (x2 > eXMax) eXMax = x2;
      if (x2 > x && rowEnd > y) begin
        if (y < eYMin) eYMin = y;
        if (rowEnd - 1 > eYMax) eYMax = rowEnd - 1;
      end
    end
    pkt[0] = cmd; pkt[4] = lw; pkt[5] = attr; pkt[6] = v1; pkt[7] = v2;
    pkt[1] = 32'hDEAD0001; pkt[2] = 32'hDEAD0002; pkt[3] = 32'hDEAD0003;
    pixDepth24 = d24;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R12 busy after start", busy, 1);
    if (pokeStart) begin
      @(negedge clk); @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check("R12 done without busy", busy, 0);
    @(negedge clk);
    check("R12 done single pulse", done, 0);
    check({tag, " all expected writes seen"}, expAddr.size(), 0);
    check("R11 dirty x min", dirtyXMin, eXMin);
    check("R11 dirty x max", dirtyXMax, eXMax);
    check("R11 dirty y min", dirtyYMin, eYMin);
    check("R11 dirty y max", dirtyYMax, eYMax);
    if (pokeStart) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check("R12 late start ignored", busy, 0);
      end
    end
    expAddr.delete(); expData.delete();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) pkt[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 fbWrEn", fbWrEn, 0);
    check("R1 x min", dirtyXMin, 4095);
    check("R1 y max", dirtyYMax, 0);
    rst = 1'b0;
    // R7 grey 0xC0, R9 order, R2 fetch
    runCase("R7", 32'h411, 0, 32'h0007_0000, packXY(10, 5), packXY(13, 7), 1'b1, 1'b0);
    // R4 subtraction alters row field; R6 quarter line width adds 3 rows
    runCase("R4", 32'h411, 13, 32'h0003_0000, packXY(20, 40) + 13, packXY(22, 41) + 13, 1'b1, 1'b0);
    // R8 8-bit low byte
    runCase("R8", 32'h411, 0, 32'h0000_00AB, packXY(100, 9), packXY(104, 10), 1'b0, 1'b0);
    // R7 grey 0
    runCase("R7", 32'h411, 0, 32'h0000_00FF, packXY(3, 3), packXY(5, 4), 1'b1, 1'b0);
    // R3 mismatched command
    runCase("R3", 32'h410, 0, 32'h0007_0000, packXY(0, 0), packXY(30, 30), 1'b1, 1'b0);
    // R10 empty width grows only x box
    runCase("R10", 32'h411, 0, 32'h0001_0000, packXY(2, 50), packXY(2, 60), 1'b1, 1'b0);
    // R10 empty height
    runCase("R10", 32'h411, 0, 32'h0001_0000, packXY(8, 60), packXY(12, 60), 1'b1, 1'b0);
    // R5 column cap
    runCase("R5", 32'h411, 0, 32'h0001_0000, packXY(700, 200), packXY(2000, 201), 1'b1, 1'b0);
    // R6 row cap at frame height
    runCase("R6", 32'h411, 15, 32'h0000_0042, packXY(4, 1022) + 15, packXY(6, 1023) + 15, 1'b0, 1'b0);
    // R12 start during a run is ignored
    runCase("R12", 32'h411, 0, 32'h0007_0000, packXY(30, 300), packXY(40, 302), 1'b1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule